// File: doc/BRIEF.md
# Timer Register Bank Access Unit

This block is the memory-mapped register front end of a multi-timer event counter. A host issues single-cycle requests carrying a byte address, a byte count and write data. Internally every register is a 64-bit word. A narrow read takes the addressed byte lanes out of that word. A narrow write replaces only its own lanes and leaves the rest of the word unchanged. Fixed per-register write masks keep read-only and reserved bits at their current values.

The unit holds the general configuration (run enable and legacy routing select) and a free-running main counter. For each timer channel it holds a configuration word, a comparator word and a routing word, and it exports all of them to the channel logic. The main counter advances once per clock while the enable is set, and a read returns its live value. Writes that turn the enable on or off produce one-cycle start and stop pulses for the channels. A constant capability word gives the counter size, the timer count and the tick period.

Top module: `tbank_regfile`

## Requirements
- R1: An access is legal only when `len_i` is 1, 2, 4 or 8 and `addr_i` is a multiple of `len_i`. An illegal access raises `err_o` for one cycle in the response slot. An illegal read returns all ones, and an illegal write changes no register.
- R2: A legal read of fewer than 8 bytes returns the addressed 64-bit word shifted right by 8 × (`addr_i` mod 8) and masked to `len_i` bytes, with the upper bits zero.
- R3: A legal write of fewer than 8 bytes uses only the low `len_i` bytes of `wdata_i`, places them at byte lane (`addr_i` mod 8), and keeps every other byte of the word.
- R4: In the general configuration word at 0x010, only bit 0 (run enable, `cfg_enable_o`) and bit 1 (legacy route, `cfg_legacy_o`) are writable. All other bits read as zero.
- R5: Each timer configuration word resets to 0x000000F0_00000030. Only the bits set in mask 0x3F4E are writable, and every other bit keeps its value.
- R6: The capability word at 0x000 reads {PERIOD_FS[31:0], 0x8086A201}. The low half has revision 1 in bits 7:0, the timer count minus one in bits 12:8, the 64-bit counter flag in bit 13 and the legacy-route flag in bit 15. Writes to this word are ignored.
- R7: The main counter is at 0x0F0. Timer n has its configuration at 0x100 + 0x20·n, its comparator at +0x08 and its routing word at +0x10. Comparators reset to all ones and routing words reset to zero, and both are fully writable.
- R8: Offsets at or above 0x100 + 0x20·NUM_TMR, and every unmapped offset below that, read as zero. Writes to them are dropped.
- R9: While the run enable is 1 the counter advances by one every clock, and while it is 0 the counter holds. A read returns the value the counter had in the request cycle.
- R10: A counter write always loads the merged value. `cnt_warn_o` pulses in the response slot only when the counter was running at the time of the write.
- R11: A write that moves the run enable from 0 to 1 pulses `timer_start_o`, and a write that moves it from 1 to 0 pulses `timer_stop_o`. Each pulse lasts one cycle and coincides with the new enable value. A write that leaves the enable unchanged pulses neither.
- R12: The response arrives in the cycle after the request. `rvalid_o` is high for one cycle after each read only, and writes never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address within the window |
| len_i | input | 4 | Access size in bytes |
| wdata_i | input | 64 | Write data, right-aligned |
| rdata_o | output | 64 | Read data, right-aligned |
| rvalid_o | output | 1 | Read response valid |
| err_o | output | 1 | Illegal size or alignment |
| cnt_warn_o | output | 1 | Counter written while running |
| cfg_enable_o | output | 1 | Global run enable |
| cfg_legacy_o | output | 1 | Legacy routing select |
| timer_start_o | output | 1 | Enable rising pulse |
| timer_stop_o | output | 1 | Enable falling pulse |
| count_o | output | 64 | Live main counter |
| tmr_cfg_o | output | 64·NUM_TMR | Timer configuration words |
| tmr_cmp_o | output | 64·NUM_TMR | Timer comparator words |
| tmr_route_o | output | 64·NUM_TMR | Timer routing words |

## Verification
One routing word is loaded with a distinct value in every byte. It is then read at widths 1, 2 and 4 at several lane offsets, which exposes any wrong shift or mask. Narrow writes whose data carries nonzero upper bits, followed by full reads, tell lane merging apart from whole-word overwrite and from leakage of unused data bytes. All-ones and all-zeros writes to the masked configuration words, the capability word and unmapped offsets show which bits are protected. A timed start/stop sequence checks the counter values, the live read, the running write and the edge pulses.

// File: rtl/tbank_pkg.sv
package tbank_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_CAP, SEL_GCFG, SEL_CNT, SEL_TCFG, SEL_TCMP, SEL_TROUTE
  } reg_sel_e;

  localparam int unsigned DW         = 64;
  localparam int unsigned OFF_GCFG   = 'h010;
  localparam int unsigned OFF_CNT    = 'h0F0;
  localparam int unsigned OFF_TMR    = 'h100;
  localparam int unsigned TMR_STRIDE = 'h20;

  localparam logic [DW-1:0] GCFG_WMASK = 64'h0000_0000_0000_0003;
  localparam logic [DW-1:0] TCFG_WMASK = 64'h0000_0000_0000_3F4E;
  localparam logic [DW-1:0] TCFG_RST   = 64'h0000_00F0_0000_0030;
endpackage

// File: rtl/tbank_access_check.sv
module tbank_access_check (
  input  logic [2:0]  lo_addr_i,
  input  logic [3:0]  len_i,
  output logic        ok_o,
  output logic [5:0]  shift_o,
  output logic [63:0] width_o
);
  logic       legal;
  logic [2:0] low_mask;

  always_comb begin
    legal    = 1'b1;
    low_mask = 3'd0;
    width_o  = '0;
    unique case (len_i)
      4'd1: begin width_o = 64'h0000_0000_0000_00FF; low_mask = 3'd0; end
      4'd2: begin width_o = 64'h0000_0000_0000_FFFF; low_mask = 3'd1; end
      4'd4: begin width_o = 64'h0000_0000_FFFF_FFFF; low_mask = 3'd3; end
      4'd8: begin width_o = '1;                      low_mask = 3'd7; end
      default: legal = 1'b0;
    endcase
    ok_o    = legal && ((lo_addr_i & low_mask) == 3'd0);
    shift_o = {lo_addr_i, 3'b000};
  end
endmodule

// File: rtl/tbank_lane.sv
module tbank_lane (
  input  logic [63:0] old_i,
  input  logic [63:0] wdata_i,
  input  logic [63:0] width_i,
  input  logic [5:0]  shift_i,
  output logic [63:0] rd_o,
  output logic [63:0] merged_o
);
  logic [63:0] lane_mask;

  always_comb begin
    lane_mask = width_i << shift_i;
    rd_o      = (old_i >> shift_i) & width_i;
    merged_o  = (old_i & ~lane_mask) | ((wdata_i & width_i) << shift_i);
  end
endmodule

// File: rtl/tbank_decode.sv
module tbank_decode
  import tbank_pkg::*;
#(
  parameter int unsigned AW      = 10,
  parameter int unsigned NUM_TMR = 3,
  parameter int unsigned TIW     = 2
) (
  input  logic [AW-1:0]  addr_i,
  output reg_sel_e       sel_o,
  output logic [TIW-1:0] idx_o
);
  localparam int unsigned SW = $clog2(TMR_STRIDE);
  localparam logic [AW:0] TMR_LO = (AW+1)'(OFF_TMR);
  localparam logic [AW:0] TMR_HI = (AW+1)'(OFF_TMR + NUM_TMR * TMR_STRIDE);
  localparam logic [AW:0] GCFG_A = (AW+1)'(OFF_GCFG);
  localparam logic [AW:0] CNT_A  = (AW+1)'(OFF_CNT);

  logic [AW:0] off;
  logic [AW:0] rel;

  always_comb begin
    off   = {1'b0, addr_i[AW-1:3], 3'b000};
    rel   = off - TMR_LO;
    idx_o = TIW'(rel >> SW);
    sel_o = SEL_NONE;
    if (off == '0)          sel_o = SEL_CAP;
    else if (off == GCFG_A) sel_o = SEL_GCFG;
    else if (off == CNT_A)  sel_o = SEL_CNT;
    else if (off >= TMR_LO && off < TMR_HI) begin
      unique case (rel[SW-1:3])
        2'd0:    sel_o = SEL_TCFG;
        2'd1:    sel_o = SEL_TCMP;
        2'd2:    sel_o = SEL_TROUTE;
        default: sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/tbank_main_counter.sv
module tbank_main_counter #(
  parameter int unsigned CW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (en_i)   cnt_o <= cnt_o + CW'(1);
  end

  assert_count_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !$past(load_i)) |-> cnt_o == $past(cnt_o) + CW'(1));
  assert_count_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(en_i) && !$past(load_i)) |-> $stable(cnt_o));
  assert_count_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) |-> cnt_o == $past(load_val_i));
endmodule

// File: rtl/tbank_regfile.sv
module tbank_regfile
  import tbank_pkg::*;
#(
  parameter int unsigned AW        = 10,
  parameter int unsigned NUM_TMR   = 3,
  parameter int unsigned PERIOD_FS = 8000000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [3:0]            len_i,
  input  logic [63:0]           wdata_i,
  output logic [63:0]           rdata_o,
  output logic                  rvalid_o,
  output logic                  err_o,
  output logic                  cnt_warn_o,
  output logic                  cfg_enable_o,
  output logic                  cfg_legacy_o,
  output logic                  timer_start_o,
  output logic                  timer_stop_o,
  output logic [63:0]           count_o,
  output logic [64*NUM_TMR-1:0] tmr_cfg_o,
  output logic [64*NUM_TMR-1:0] tmr_cmp_o,
  output logic [64*NUM_TMR-1:0] tmr_route_o
);
  localparam int unsigned TIW = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;
  localparam logic [63:0] CAP_WORD = {32'(PERIOD_FS), 16'h8086, 1'b1, 1'b0, 1'b1,
                                      5'(NUM_TMR - 1), 8'h01};

  logic            acc_ok;
  logic [5:0]      shift;
  logic [63:0]     width;
  reg_sel_e        sel;
  logic [TIW-1:0]  idx;
  logic [63:0]     reg_val, wmask, rd_lane, merged, new_word;
  logic [1:0]      gcfg_q;
  logic [63:0]     tcfg_q  [NUM_TMR];
  logic [63:0]     tcmp_q  [NUM_TMR];
  logic [63:0]     troute_q[NUM_TMR];
  logic            wr, wr_gcfg, wr_cnt;

  tbank_access_check u_chk (
    .lo_addr_i (addr_i[2:0]),
    .len_i     (len_i),
    .ok_o      (acc_ok),
    .shift_o   (shift),
    .width_o   (width)
  );

  tbank_decode #(.AW(AW), .NUM_TMR(NUM_TMR), .TIW(TIW)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .idx_o  (idx)
  );

  always_comb begin
    reg_val = '0;
    wmask   = '0;
    unique case (sel)
      SEL_CAP:    reg_val = CAP_WORD;
      SEL_GCFG:   begin reg_val = {62'b0, gcfg_q}; wmask = GCFG_WMASK; end
      SEL_CNT:    begin reg_val = count_o;         wmask = '1;         end
      SEL_TCFG:   begin reg_val = tcfg_q[idx];     wmask = TCFG_WMASK; end
      SEL_TCMP:   begin reg_val = tcmp_q[idx];     wmask = '1;         end
      SEL_TROUTE: begin reg_val = troute_q[idx];   wmask = '1;         end
      default:    ;
    endcase
  end

  tbank_lane u_lane (
    .old_i    (reg_val),
    .wdata_i  (wdata_i),
    .width_i  (width),
    .shift_i  (shift),
    .rd_o     (rd_lane),
    .merged_o (merged)
  );

  assign new_word = (merged & wmask) | (reg_val & ~wmask);
  assign wr       = req_i && we_i && acc_ok;
  assign wr_gcfg  = wr && (sel == SEL_GCFG);
  assign wr_cnt   = wr && (sel == SEL_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gcfg_q        <= '0;
      rdata_o       <= '0;
      rvalid_o      <= 1'b0;
      err_o         <= 1'b0;
      cnt_warn_o    <= 1'b0;
      timer_start_o <= 1'b0;
      timer_stop_o  <= 1'b0;
    end else begin
      if (wr_gcfg) gcfg_q <= new_word[1:0];
      if (req_i && !we_i) rdata_o <= acc_ok ? rd_lane : '1;
      rvalid_o      <= req_i && !we_i;
      err_o         <= req_i && !acc_ok;
      cnt_warn_o    <= wr_cnt && gcfg_q[0];
      timer_start_o <= wr_gcfg && !gcfg_q[0] && new_word[0];
      timer_stop_o  <= wr_gcfg && gcfg_q[0] && !new_word[0];
    end
  end

  assign cfg_enable_o = gcfg_q[0];
  assign cfg_legacy_o = gcfg_q[1];

  tbank_main_counter #(.CW(64)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (gcfg_q[0]),
    .load_i     (wr_cnt),
    .load_val_i (new_word),
    .cnt_o      (count_o)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic hit;
    assign hit = wr && (idx == TIW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tcfg_q[i]   <= TCFG_RST;
        tcmp_q[i]   <= '1;
        troute_q[i] <= '0;
      end else if (hit) begin
        if (sel == SEL_TCFG)   tcfg_q[i]   <= new_word;
        if (sel == SEL_TCMP)   tcmp_q[i]   <= new_word;
        if (sel == SEL_TROUTE) troute_q[i] <= new_word;
      end
    end

    assign tmr_cfg_o[64*i +: 64]   = tcfg_q[i];
    assign tmr_cmp_o[64*i +: 64]   = tcmp_q[i];
    assign tmr_route_o[64*i +: 64] = troute_q[i];

    assert_tcfg_ro_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $stable(tcfg_q[i] & ~TCFG_WMASK));
  end

  assert_err_ones_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && err_o) |-> rdata_o == '1);
  assert_rvalid_src_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));
  assert_start_edge_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_start_o |-> (cfg_enable_o && !$past(cfg_enable_o)));
  assert_stop_edge_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_stop_o |-> (!cfg_enable_o && $past(cfg_enable_o)));
  assert_rise_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_enable_o) |-> timer_start_o);
  assert_warn_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_warn_o |-> (cfg_enable_o && $past(cfg_enable_o)));
endmodule

// File: tb/sim_tbank_regfile.sv
`timescale 1ns/1ps
module sim_tbank_regfile;
  localparam int unsigned AW = 10;
  localparam int unsigned NT = 3;
  localparam logic [63:0] CAP  = 64'h007A_1200_8086_A201;
  localparam logic [63:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0] len = 4'd0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata, count;
  logic rvalid, err, warn, en, legacy, start, stop;
  logic [64*NT-1:0] tcfg, tcmp, troute;
  int checks = 0, errs = 0;

  always #4 clk = ~clk;

  tbank_regfile #(.AW(AW), .NUM_TMR(NT), .PERIOD_FS(8000000)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .len_i(len), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .err_o(err), .cnt_warn_o(warn), .cfg_enable_o(en), .cfg_legacy_o(legacy),
    .timer_start_o(start), .timer_stop_o(stop), .count_o(count),
    .tmr_cfg_o(tcfg), .tmr_cmp_o(tcmp), .tmr_route_o(troute)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  len;
    logic [9:0]  addr;
    logic [63:0] data;
    logic [63:0] exp;
    logic        err;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd8, 10'h000, 64'h0, CAP, 1'b0, "R6"},
    '{1'b1, 4'd8, 10'h000, ONES, 64'h0, 1'b0, "R6"},
    '{1'b0, 4'd8, 10'h000, 64'h0, CAP, 1'b0, "R6"},
    '{1'b0, 4'd4, 10'h004, 64'h0, 64'h007A_1200, 1'b0, "R2"},
    '{1'b0, 4'd8, 10'h100, 64'h0, 64'h0000_00F0_0000_0030, 1'b0, "R5"},
    '{1'b0, 4'd8, 10'h108, 64'h0, ONES, 1'b0, "R7"},
    '{1'b0, 4'd8, 10'h110, 64'h0, 64'h0, 1'b0, "R7"},
    '{1'b1, 4'd8, 10'h110, 64'h1122_3344_5566_7788, 64'h0, 1'b0, "R7"},
    '{1'b0, 4'd8, 10'h110, 64'h0, 64'h1122_3344_5566_7788, 1'b0, "R7"},
    '{1'b0, 4'd1, 10'h113, 64'h0, 64'h55, 1'b0, "R2"},
    '{1'b0, 4'd2, 10'h116, 64'h0, 64'h1122, 1'b0, "R2"},
    '{1'b0, 4'd4, 10'h114, 64'h0, 64'h1122_3344, 1'b0, "R2"},
    '{1'b1, 4'd1, 10'h111, 64'hFFFF_FFFF_FFFF_FFAB, 64'h0, 1'b0, "R3"},
    '{1'b0, 4'd8, 10'h110, 64'h0, 64'h1122_3344_5566_AB88, 1'b0, "R3"},
    '{1'b1, 4'd2, 10'h116, 64'h0000_0000_0000_BEEF, 64'h0, 1'b0, "R3"},
    '{1'b0, 4'd8, 10'h110, 64'h0, 64'hBEEF_3344_5566_AB88, 1'b0, "R3"},
    '{1'b1, 4'd4, 10'h110, 64'h1234_5678_CAFE_F00D, 64'h0, 1'b0, "R3"},
    '{1'b0, 4'd8, 10'h110, 64'h0, 64'hBEEF_3344_CAFE_F00D, 1'b0, "R3"},
    '{1'b0, 4'd2, 10'h111, 64'h0, ONES, 1'b1, "R1"},
    '{1'b1, 4'd4, 10'h112, 64'h0, 64'h0, 1'b1, "R1"},
    '{1'b0, 4'd8, 10'h110, 64'h0, 64'hBEEF_3344_CAFE_F00D, 1'b0, "R1"},
    '{1'b0, 4'd3, 10'h110, 64'h0, ONES, 1'b1, "R1"},
    '{1'b1, 4'd0, 10'h110, 64'h0, 64'h0, 1'b1, "R1"},
    '{1'b1, 4'd8, 10'h010, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 1'b0, "R4"},
    '{1'b0, 4'd8, 10'h010, 64'h0, 64'h2, 1'b0, "R4"},
    '{1'b1, 4'd8, 10'h010, 64'h0, 64'h0, 1'b0, "R4"},
    '{1'b0, 4'd8, 10'h010, 64'h0, 64'h0, 1'b0, "R4"},
    '{1'b1, 4'd8, 10'h120, ONES, 64'h0, 1'b0, "R5"},
    '{1'b0, 4'd8, 10'h120, 64'h0, 64'h0000_00F0_0000_3F7E, 1'b0, "R5"},
    '{1'b1, 4'd2, 10'h120, 64'h0, 64'h0, 1'b0, "R5"},
    '{1'b0, 4'd8, 10'h120, 64'h0, 64'h0000_00F0_0000_0030, 1'b0, "R5"},
    '{1'b1, 4'd8, 10'h148, 64'h1234_5678, 64'h0, 1'b0, "R7"},
    '{1'b0, 4'd8, 10'h148, 64'h0, 64'h1234_5678, 1'b0, "R7"},
    '{1'b1, 4'd8, 10'h160, ONES, 64'h0, 1'b0, "R8"},
    '{1'b0, 4'd8, 10'h160, 64'h0, 64'h0, 1'b0, "R8"},
    '{1'b1, 4'd8, 10'h018, ONES, 64'h0, 1'b0, "R8"},
    '{1'b0, 4'd8, 10'h018, 64'h0, 64'h0, 1'b0, "R8"},
    '{1'b0, 4'd8, 10'h3F8, 64'h0, 64'h0, 1'b0, "R8"},
    '{1'b0, 4'd4, 10'h15C, 64'h0, 64'h0, 1'b0, "R8"}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive just after a falling edge; result is sampled at the next falling edge.
  task automatic acc(input logic w, input logic [3:0] l, input logic [AW-1:0] a,
                     input logic [63:0] d);
    req = 1'b1; we = w; len = l; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rvalid == 1'b0 && err == 1'b0, "R12", {62'b0, rvalid, err}, 64'h0);
    chk(en == 1'b0 && count == 64'h0, "R9", count, 64'h0);
    chk(tcfg[63:0] == 64'h0000_00F0_0000_0030, "R5", tcfg[63:0], 64'h0000_00F0_0000_0030);
    chk(tcmp[127:64] == ONES, "R7", tcmp[127:64], ONES);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      acc(VECS[i].we, VECS[i].len, VECS[i].addr, VECS[i].data);
      chk(err == VECS[i].err, $sformatf("%s err v%0d", VECS[i].tag, i),
          {63'b0, err}, {63'b0, VECS[i].err});
      if (VECS[i].we)
        chk(rvalid == 1'b0, "R12 write", {63'b0, rvalid}, 64'h0);
      else begin
        chk(rvalid == 1'b1, "R12 read", {63'b0, rvalid}, 64'h1);
        chk(rdata == VECS[i].exp, $sformatf("%s data v%0d", VECS[i].tag, i),
            rdata, VECS[i].exp);
      end
    end
    chk(troute[63:0] == 64'hBEEF_3344_CAFE_F00D, "R3 port", troute[63:0],
        64'hBEEF_3344_CAFE_F00D);

    // counter load while stopped
    acc(1'b1, 4'd8, 10'h0F0, 64'h100);
    chk(warn == 1'b0, "R10 stopped", {63'b0, warn}, 64'h0);
    chk(count == 64'h100, "R10 load", count, 64'h100);
    // start
    acc(1'b1, 4'd8, 10'h010, 64'h1);
    chk(start == 1'b1 && stop == 1'b0, "R11 start", {62'b0, start, stop}, 64'h2);
    chk(en == 1'b1, "R4 enable", {63'b0, en}, 64'h1);
    idle(3);
    acc(1'b0, 4'd8, 10'h0F0, 64'h0);
    chk(rdata == 64'h103, "R9 live", rdata, 64'h103);
    acc(1'b1, 4'd8, 10'h010, 64'h1);
    chk(start == 1'b0 && stop == 1'b0, "R11 same", {62'b0, start, stop}, 64'h0);
    acc(1'b1, 4'd8, 10'h0F0, 64'h5000);
    chk(warn == 1'b1, "R10 running", {63'b0, warn}, 64'h1);
    chk(count == 64'h5000, "R10 running load", count, 64'h5000);
    acc(1'b1, 4'd8, 10'h010, 64'h0);
    chk(stop == 1'b1 && start == 1'b0, "R11 stop", {62'b0, start, stop}, 64'h1);
    chk(count == 64'h5001, "R9 last step", count, 64'h5001);
    idle(3);
    acc(1'b0, 4'd8, 10'h0F0, 64'h0);
    chk(rdata == 64'h5001, "R9 hold", rdata, 64'h5001);
    acc(1'b1, 4'd2, 10'h0F2, 64'hFFFF_ABCD);
    chk(count == 64'hABCD_5001, "R3 counter lanes", count, 64'hABCD_5001);
    chk(warn == 1'b0, "R10 idle write", {63'b0, warn}, 64'h0);
    acc(1'b1, 4'd1, 10'h010, 64'h2);
    chk(legacy == 1'b1 && en == 1'b0 && start == 1'b0, "R4 legacy",
        {61'b0, legacy, en, start}, 64'h4);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule